// File: doc/BRIEF.md
# Signed Squaring Unit with Selectable Latency

The unit returns the square of a signed two's-complement operand. The operand width `W` and the latency `L` are independent parameters. It does not use a general multiplier. It uses the fact that both factors are equal. The base of the result is the operand with a zero placed between each pair of bits, so operand bit i lands at position 2i. Step i then adds bit i times the operand bits below it, starting at position 2i+1.

The running partial sum moves one place right after each step, so the operand never has to be shifted left. The result register starts out holding the operand. Each bit of the result that has settled is pushed in from the top and takes the place of an operand bit that is no longer needed. For a negative operand, the steps have treated its bits as an unsigned number. A final correction subtracts the resulting error term by adding the inverted lower operand bits with a carry-in of one, shifted into position.

A caller drives the operand, pulses `start_i` for one cycle, and keeps the operand stable until `ready_o` pulses. The result is valid only in that pulse cycle. When `L` is 0 the whole datapath is combinational. When `L` is greater than 0, each cycle performs ceil(max(W,L)/L) steps.

Top module: `squarer`

## Requirements
- R1: In the cycle where `ready_o` is high, `square_o` equals operand × operand as a non-negative 2W-bit value, for every signed operand including the most negative one; its top bit is 0.
- R2: With L > 0, a start pulse in cycle t accepted while idle gives exactly one `ready_o` pulse, in cycle t+L and in no other cycle.
- R3: With L = 0, `ready_o` equals `start_i` in the same cycle and `square_o` is valid in that cycle; start may stay high on consecutive cycles with a new operand each cycle.
- R4: With L > 0, a start pulse that arrives while a calculation is running, including its ready cycle, is ignored: it neither restarts the count nor adds a ready pulse.
- R5: When `ready_o` is high, `square_o[1]` is 0 and `square_o[0]` equals `operand_i[0]`.
- R6: When L > W, the operand is sign-extended internally to L bits and one step runs per cycle; the result is still correct and still appears after exactly L cycles.
- R7: Reset is asynchronous and active low. During reset `ready_o` is low. A calculation cut short by reset produces no ready pulse afterwards. With the operand at 0, `square_o` reads 0 in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that begins a calculation |
| operand_i | input | W | Signed operand, held stable until ready |
| ready_o | output | 1 | One-cycle pulse marking a valid result |
| square_o | output | 2W | Non-negative square, valid while ready_o is high |

## Verification
The bench builds the unit with six parameter sets:
- W=8 with L=3, where steps per cycle exceed one and the last cycle has an idle slot.
- W=4 with L=0 (combinational) and with L=1 (all steps in one cycle).
- W=5 with L=5 (one step per cycle).
- W=5 with L=7 and W=8 with L=10, which exercise internal sign extension.

All instances are fed every 8-bit pattern, so the 4- and 5-bit instances see every operand many times and the 8-bit instances see every operand, including the most negative one. Directed phases cover the following:
- a start pulse arriving mid-calculation;
- reset applied during a calculation;
- back-to-back starts on the combinational instance.

// File: rtl/sq_pkg.sv
package sq_pkg;

  // Internal operand width: widened to L when latency exceeds width.
  function automatic int ext_width(int w, int l);
    return (l > w) ? l : w;
  endfunction

  function automatic int steps_per_cycle(int w, int l);
    int n;
    n = ext_width(w, l);
    return (l == 0) ? n : (n + l - 1) / l;
  endfunction

endpackage

// File: rtl/sq_step.sv
// One algorithm step: add bit k times lower operand bits plus the spread bit,
// then shift the partial sum right by one into the result register.
module sq_step #(
  parameter int N  = 8,
  parameter int IW = 5
) (
  input  logic [2*N-1:0] res_i,
  input  logic [N-1:0]   op_i,
  input  logic [IW-1:0]  idx_i,
  output logic [2*N-1:0] res_o
);
  logic       en;
  logic [N:0] one_k, mask, part, addend, sum;

  always_comb begin
    en     = (idx_i < IW'(N));
    one_k  = (N+1)'(1) << idx_i;
    mask   = one_k - (N+1)'(1);
    part   = {1'b0, op_i} & mask;
    addend = res_i[0] ? (one_k + (part << 1)) : '0;
    sum    = {1'b0, res_i[2*N-1:N]} + addend;
    res_o  = en ? {sum, res_i[N-1:1]} : res_i;
  end
endmodule

// File: rtl/sq_fix.sv
// Sign correction: remove op*2^(N+1) for negative operands, then trim to 2W.
module sq_fix #(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic [2*N-1:0] res_i,
  input  logic [N-1:0]   op_i,
  output logic [2*W-1:0] sq_o
);
  logic [N-1:0]   corr, hi;
  logic [2*N-1:0] full;

  always_comb begin
    corr = op_i[N-1] ? (({1'b0, ~op_i[N-2:0]} + N'(1)) << 1) : '0;
    hi   = res_i[2*N-1:N] + corr;
    full = {hi, res_i[N-1:0]};
    sq_o = full[2*W-1:0];
  end
endmodule

// File: rtl/sq_ctrl.sv
module sq_ctrl #(
  parameter int L  = 3,
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          accept_o,
  output logic          ready_o,
  output logic [CW-1:0] cyc_o
);
  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign accept_o = start_i && !busy_q;
  assign ready_o  = busy_q && (cnt_q == CW'(L));
  assign busy_o   = busy_q;
  assign cyc_o    = busy_q ? cnt_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(1);
    end else if (busy_q) begin
      if (cnt_q == CW'(L)) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assert_ready_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  assert_busy_from_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(start_i));

  assert_start_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> (cnt_q != CW'(1)));
endmodule

// File: rtl/squarer.sv
module squarer
  import sq_pkg::*;
#(
  parameter int W = 8,
  parameter int L = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [W-1:0]   operand_i,
  output logic           ready_o,
  output logic [2*W-1:0] square_o
);
  localparam int N  = ext_width(W, L);
  localparam int S  = steps_per_cycle(W, L);
  localparam int IW = $clog2(3*N + 2) + 1;
  localparam int CW = $clog2(L + 2) + 1;

  logic [N-1:0]   op_ext;
  logic [2*N-1:0] res_full;

  assign op_ext = N'($signed(operand_i));

  generate
    if (L == 0) begin : g_comb
      logic [2*N-1:0] chain [N+1];
      assign chain[0] = {N'(0), op_ext};
      for (genvar j = 0; j < N; j++) begin : g_step
        sq_step #(.N(N), .IW(IW)) u_step (
          .res_i(chain[j]), .op_i(op_ext), .idx_i(IW'(j)), .res_o(chain[j+1])
        );
      end
      assign res_full = chain[N];
      assign ready_o  = start_i;
    end else begin : g_seq
      logic           busy, accept, rdy;
      logic [CW-1:0]  cyc;
      logic [2*N-1:0] res_q;
      logic [2*N-1:0] chain [S+1];

      sq_ctrl #(.L(L), .CW(CW)) u_ctrl (
        .clk_i, .rst_ni, .start_i,
        .busy_o(busy), .accept_o(accept), .ready_o(rdy), .cyc_o(cyc)
      );

      // Result register seeded with the operand on the start cycle.
      assign chain[0] = busy ? res_q : {N'(0), op_ext};
      for (genvar j = 0; j < S; j++) begin : g_step
        sq_step #(.N(N), .IW(IW)) u_step (
          .res_i(chain[j]), .op_i(op_ext),
          .idx_i(IW'(int'(cyc) * S + j)), .res_o(chain[j+1])
        );
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   res_q <= '0;
        else if (accept || (busy && !rdy)) res_q <= chain[S];
      end

      assign res_full = res_q;
      assign ready_o  = rdy;
    end
  endgenerate

  sq_fix #(.N(N), .W(W)) u_fix (.res_i(res_full), .op_i(op_ext), .sq_o(square_o));

  assert_low_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (square_o[1] == 1'b0 && square_o[0] == operand_i[0]));

  assert_nonneg_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (square_o[2*W-1] == 1'b0));
endmodule

// File: tb/tb_sq_mon.sv
// Per-instance reference model: predicts ready timing, checks value on ready.
module tb_sq_mon #(
  parameter int W = 4,
  parameter int L = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic signed [W-1:0]   op,
  input  logic                  ready,
  input  logic [2*W-1:0]        sq,
  output int                    n_chk,
  output int                    n_bad
);
  int             chk = 0;
  int             bad = 0;
  int             rem = 0;
  bit             busy_m = 1'b0;
  logic           exp_rdy;
  logic [2*W-1:0] e;

  assign n_chk = chk;
  assign n_bad = bad;

  always @(negedge clk) begin
    if (!rst_n) begin
      busy_m = 1'b0;
      rem    = 0;
      chk++;
      if (ready !== 1'b0) begin
        bad++;
        $display("FAIL R7 W=%0d L=%0d ready in reset: act=%b exp=0", W, L, ready);
      end
    end else begin
      exp_rdy = 1'b0;
      if (L == 0) exp_rdy = start;
      else if (busy_m) begin
        rem--;
        if (rem == 0) begin
          exp_rdy = 1'b1;
          busy_m  = 1'b0;
        end
      end else if (start) begin
        busy_m = 1'b1;
        rem    = L;
      end
      if (exp_rdy || ready) begin
        chk++;
        if (ready !== exp_rdy) begin
          bad++;
          $display("FAIL %s W=%0d L=%0d ready: act=%b exp=%b",
                   (L == 0) ? "R3" : "R2/R4", W, L, ready, exp_rdy);
        end
      end
      if (exp_rdy) begin
        e = $signed(op) * $signed(op);
        chk++;
        if (sq !== e) begin
          bad++;
          $display("FAIL R1 W=%0d L=%0d op=%0d: act=%0d exp=%0d", W, L, op, sq, e);
        end
        chk++;
        if (sq[1:0] !== {1'b0, op[0]}) begin
          bad++;
          $display("FAIL R5 W=%0d L=%0d low bits: act=%b exp=%b", W, L, sq[1:0], {1'b0, op[0]});
        end
      end
    end
  end
endmodule

// File: tb/tb_squarer.sv
`timescale 1ns/1ps
module tb_squarer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       start_b2b = 1'b0;
  logic       start_z;
  logic [7:0] op = '0;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;
  assign start_z = start | start_b2b;

  logic        rdy_m, rdy_a, rdy_b, rdy_c, rdy_d, rdy_e;
  logic [15:0] sq_m, sq_e;
  logic [7:0]  sq_a, sq_b;
  logic [9:0]  sq_c, sq_d;
  int c_m, b_m, c_a, b_a, c_b, b_b, c_c, b_c, c_d, b_d, c_e, b_e;

  squarer #(.W(8), .L(3)) dut (.clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .operand_i(op), .ready_o(rdy_m), .square_o(sq_m));
  // R3: combinational instance, also driven back to back
  squarer #(.W(4), .L(0)) u_w4_l0 (.clk_i(clk), .rst_ni(rst_n), .start_i(start_z),
    .operand_i(op[3:0]), .ready_o(rdy_a), .square_o(sq_a));
  squarer #(.W(4), .L(1)) u_w4_l1 (.clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .operand_i(op[3:0]), .ready_o(rdy_b), .square_o(sq_b));
  squarer #(.W(5), .L(5)) u_w5_l5 (.clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .operand_i(op[4:0]), .ready_o(rdy_c), .square_o(sq_c));
  // R6: latency above width, internal sign extension
  squarer #(.W(5), .L(7)) u_w5_l7 (.clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .operand_i(op[4:0]), .ready_o(rdy_d), .square_o(sq_d));
  squarer #(.W(8), .L(10)) u_w8_l10 (.clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .operand_i(op), .ready_o(rdy_e), .square_o(sq_e));

  tb_sq_mon #(.W(8), .L(3))  m_m (.clk, .rst_n, .start(start), .op(op), .ready(rdy_m), .sq(sq_m), .n_chk(c_m), .n_bad(b_m));
  tb_sq_mon #(.W(4), .L(0))  m_a (.clk, .rst_n, .start(start_z), .op(op[3:0]), .ready(rdy_a), .sq(sq_a), .n_chk(c_a), .n_bad(b_a));
  tb_sq_mon #(.W(4), .L(1))  m_b (.clk, .rst_n, .start(start), .op(op[3:0]), .ready(rdy_b), .sq(sq_b), .n_chk(c_b), .n_bad(b_b));
  tb_sq_mon #(.W(5), .L(5))  m_c (.clk, .rst_n, .start(start), .op(op[4:0]), .ready(rdy_c), .sq(sq_c), .n_chk(c_c), .n_bad(b_c));
  tb_sq_mon #(.W(5), .L(7))  m_d (.clk, .rst_n, .start(start), .op(op[4:0]), .ready(rdy_d), .sq(sq_d), .n_chk(c_d), .n_bad(b_d));
  tb_sq_mon #(.W(8), .L(10)) m_e (.clk, .rst_n, .start(start), .op(op), .ready(rdy_e), .sq(sq_e), .n_chk(c_e), .n_bad(b_e));

  // {operand, expected square} for the W=8, L=3 instance
  localparam logic [23:0] VEC [16] = '{
    {8'h00, 16'h0000}, {8'h01, 16'h0001}, {8'hFF, 16'h0001}, {8'h7F, 16'h3F01},
    {8'h80, 16'h4000}, {8'h81, 16'h3F01}, {8'h02, 16'h0004}, {8'hFE, 16'h0004},
    {8'h0F, 16'h00E1}, {8'hF1, 16'h00E1}, {8'h55, 16'h1C39}, {8'hAA, 16'h1CE4},
    {8'h10, 16'h0100}, {8'hC0, 16'h1000}, {8'h40, 16'h1000}, {8'h33, 16'h0A29}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic launch(logic [7:0] v);
    op    = v;
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
  endtask

  task automatic summary();
    int tc, tb;
    tc = n_chk + c_m + c_a + c_b + c_c + c_d + c_e;
    tb = n_bad + b_m + b_a + b_b + b_c + b_d + b_e;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", tc, tb);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      check("R7 reset ready", 32'(rdy_m), 32'd0);
      check("R7 reset square", 32'(sq_m), 32'd0);
    end
    @(posedge clk); #1 rst_n = 1'b1;

    // R1/R2: table walk on the main instance, ready expected 3 cycles after start
    for (int i = 0; i < 16; i++) begin
      @(posedge clk); #1;
      launch(VEC[i][23:16]);
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R2 ready at L", 32'(rdy_m), 32'd1);
      check("R1 table square", 32'(sq_m), 32'(VEC[i][15:0]));
      repeat (12) @(posedge clk);
    end

    // R1/R6: every 8-bit pattern through all instances (monitors check)
    for (int v = 0; v < 256; v++) begin
      @(posedge clk); #1;
      launch(8'(v));
      repeat (12) @(posedge clk);
    end

    // R4: second start one cycle after the first is ignored
    @(posedge clk); #1;
    launch(8'hB5);
    start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R4 original ready", 32'(rdy_m), 32'd1);
    check("R4 square", 32'(sq_m), 32'd5625);
    @(posedge clk);
    @(negedge clk);
    check("R4 no second ready", 32'(rdy_m), 32'd0);
    repeat (12) @(posedge clk);

    // R7: reset during a calculation cancels it
    @(posedge clk); #1;
    launch(8'h9C);
    #1 rst_n = 1'b0;
    @(negedge clk);
    check("R7 ready in mid reset", 32'(rdy_m), 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    begin
      int pulses;
      pulses = 0;
      repeat (14) begin
        @(negedge clk);
        if (rdy_m || rdy_e) pulses++;
      end
      check("R7 no ready after cancel", 32'(pulses), 32'd0);
    end

    // R3: back-to-back starts, operand changing each cycle
    @(posedge clk); #1;
    for (int k = 0; k < 8; k++) begin
      op        = 8'(k * 37);
      start_b2b = 1'b1;
      @(negedge clk);
      check("R3 same-cycle ready", 32'(rdy_a), 32'd1);
      check("R3 b2b square", 32'(sq_a), 32'($signed(op[3:0]) * $signed(op[3:0])));
      @(posedge clk); #1;
    end
    start_b2b = 1'b0;
    repeat (4) @(posedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: act=timeout exp=completion");
      summary();
      $finish;
    end
  end
endmodule